// File: doc/BRIEF.md
# Scatter-Gather DMA Walker

This block moves a requested number of bytes between a word-wide card-side stream and system memory by walking a chain of 16-byte descriptors held in memory. A start pulse supplies the address of the first descriptor, the total byte count and the direction. For each descriptor the walker reads its four words over a 32-bit memory master port. It works out how many bytes that descriptor covers and streams those words to or from the descriptor's buffer. It then writes the status word back with its ownership flag cleared and moves to the next descriptor in the chain. When the total is used up it raises a single-cycle completion pulse.

A descriptor holds four little-endian 32-bit words. The word at offset +0 is status, +4 is buffer length in bytes, +8 is buffer address and +12 is the address of the following descriptor. Bit 31 of the status word is the ownership flag. The memory port carries one access at a time. A request is accepted in a cycle where `mem_req` and `mem_gnt` are both high, and read data comes back on a later cycle flagged by `mem_rvalid`. Both stream ports use valid/ready handshakes. All byte counts are assumed to be multiples of four.

Top module: `sg_dma_walker`

## Requirements
- R1: After reset, and whenever idle, `busy`, `done`, `mem_req`, `in_ready` and `out_valid` are all low.
- R2: Each descriptor is fetched as four word reads, in the order +0, +4, +8, +12 from its address, before any access to its buffer.
- R3: The number of bytes taken from a descriptor is the smaller of its length word and the bytes still outstanding in the transfer, so the last descriptor may be only partly used.
- R4: A length word of 0 stands for 65536 bytes.
- R5: With `dir_to_mem`=1 (card to memory), each accepted `in_data` word is written to consecutive word addresses from the buffer address, in arrival order.
- R6: With `dir_to_mem`=0 (memory to card), the buffer words are read from consecutive addresses and presented in order on `out_data`, held stable while `out_ready` is low.
- R7: After a descriptor's last data word, the walker writes to the descriptor's own address the fetched status word with bit 31 cleared and all other bits unchanged. This happens before any read of the next descriptor.
- R8: The walk follows each next-descriptor word and issues no further memory access once the total has been moved.
- R9: `done` is high for exactly one cycle after the final status write, and `busy` is low in the cycle after it. A start with `total_bytes`=0 gives `done` on the next cycle with no memory access.
- R10: A memory request that is not granted stays asserted with unchanged address, write enable and write data.
- R11: A `start` pulse while `busy` is high has no effect, and the inputs that go with it are not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_to_mem | input | 1 | 1: stream to memory, 0: memory to stream |
| base_addr | input | ADDR_W | Address of the first descriptor |
| total_bytes | input | CNT_W | Total bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word address in bytes |
| mem_wdata | output | WORD_W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | WORD_W | Read data |
| in_valid | input | 1 | Card-to-memory stream word valid |
| in_ready | output | 1 | Walker accepts a stream word |
| in_data | input | WORD_W | Card-to-memory stream word |
| out_valid | output | 1 | Memory-to-card stream word valid |
| out_ready | input | 1 | Receiver accepts the stream word |
| out_data | output | WORD_W | Memory-to-card stream word |

## Verification
The zero-length descriptor is the hardest case to reach. Showing that it means 64 KiB, and not 0 or a truncated value, needs a transfer of more than 65536 bytes. The chunk after it must also be clipped, so that the byte count is confirmed at both boundaries. The stimulus builds that chain with a 65544-byte total and runs it with grant and stream handshakes held open to keep the run short. It then checks the last word inside the 64 KiB buffer, the first word of the next buffer and an untouched word beyond the clip. A second hard case is a start pulse in mid-walk. The bench issues one with a different base, count and direction while a memory-to-card walk is under way, and the exact access sequence of the first walk must be unchanged.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_FREQ  = 4'd1,
        ST_FWAIT = 4'd2,
        ST_IN    = 4'd3,
        ST_WR    = 4'd4,
        ST_RD    = 4'd5,
        ST_RWAIT = 4'd6,
        ST_OUT   = 4'd7,
        ST_REL   = 4'd8,
        ST_DONE  = 4'd9
    } walk_state_e;

endpackage

// File: rtl/sgdma_chunk_calc.sv
module sgdma_chunk_calc #(
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 32,
    parameter int ZERO_BYTES = 65536
) (
    input  logic [WORD_W-1:0] size_field,
    input  logic [CNT_W-1:0]  remain,
    output logic [CNT_W-1:0]  chunk
);
    localparam int EXT_W = (WORD_W > CNT_W) ? WORD_W : CNT_W;

    logic [EXT_W-1:0] eff_len;
    logic [EXT_W-1:0] rem_ext;

    always_comb begin
        eff_len = (size_field == '0) ? EXT_W'(ZERO_BYTES) : EXT_W'(size_field);
        rem_ext = EXT_W'(remain);
        chunk   = (eff_len < rem_ext) ? CNT_W'(eff_len) : remain;
    end

endmodule

// File: rtl/sgdma_req_mux.sv
module sgdma_req_mux
    import sgdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int OWN_BIT = 31
) (
    input  walk_state_e       st,
    input  logic [ADDR_W-1:0] desc,
    input  logic [1:0]        widx,
    input  logic [ADDR_W-1:0] bufp,
    input  logic [WORD_W-1:0] hold,
    input  logic [WORD_W-1:0] status,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = bufp;
        wdata = hold;
        case (st)
            ST_FREQ: begin
                req  = 1'b1;
                addr = desc + ADDR_W'({widx, 2'b00});
            end
            ST_WR: begin
                req = 1'b1;
                we  = 1'b1;
            end
            ST_RD: begin
                req = 1'b1;
            end
            ST_REL: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = desc;
                wdata = status & ~OWN_MASK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker
    import sgdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 32,
    parameter int ZERO_BYTES = 65536,
    parameter int OWN_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_to_mem,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  total_bytes,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    localparam int BEAT_BYTES = WORD_W / 8;

    typedef struct packed {
        walk_state_e       st;
        logic              to_mem;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  chunk_left;
        logic [ADDR_W-1:0] desc;
        logic [1:0]        widx;
        logic [WORD_W-1:0] status;
        logic [ADDR_W-1:0] bufp;
        logic [ADDR_W-1:0] nxt;
        logic [WORD_W-1:0] hold;
    } walk_t;

    walk_t            q, d;
    logic [CNT_W-1:0] chunk_w;
    logic             last_beat;

    sgdma_chunk_calc #(
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W),
        .ZERO_BYTES(ZERO_BYTES)
    ) u_chunk (
        .size_field(mem_rdata),
        .remain    (q.rem),
        .chunk     (chunk_w)
    );

    sgdma_req_mux #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .OWN_BIT(OWN_BIT)
    ) u_req (
        .st    (q.st),
        .desc  (q.desc),
        .widx  (q.widx),
        .bufp  (q.bufp),
        .hold  (q.hold),
        .status(q.status),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    assign last_beat = (q.chunk_left == CNT_W'(BEAT_BYTES));

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.to_mem = dir_to_mem;
                    d.rem    = total_bytes;
                    d.desc   = base_addr;
                    d.widx   = 2'd0;
                    d.st     = (total_bytes == '0) ? ST_DONE : ST_FREQ;
                end
            end
            ST_FREQ: begin
                if (mem_gnt) d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (mem_rvalid) begin
                    case (q.widx)
                        2'd0:    d.status     = mem_rdata;
                        2'd1:    d.chunk_left = chunk_w;
                        2'd2:    d.bufp       = ADDR_W'(mem_rdata);
                        default: d.nxt        = ADDR_W'(mem_rdata);
                    endcase
                    if (q.widx == 2'd3) begin
                        d.st = q.to_mem ? ST_IN : ST_RD;
                    end else begin
                        d.widx = q.widx + 2'd1;
                        d.st   = ST_FREQ;
                    end
                end
            end
            ST_IN: begin
                if (in_valid) begin
                    d.hold = in_data;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_gnt) begin
                    d.bufp       = q.bufp + ADDR_W'(BEAT_BYTES);
                    d.chunk_left = q.chunk_left - CNT_W'(BEAT_BYTES);
                    d.rem        = q.rem - CNT_W'(BEAT_BYTES);
                    d.st         = last_beat ? ST_REL : ST_IN;
                end
            end
            ST_RD: begin
                if (mem_gnt) d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rvalid) begin
                    d.hold = mem_rdata;
                    d.st   = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    d.bufp       = q.bufp + ADDR_W'(BEAT_BYTES);
                    d.chunk_left = q.chunk_left - CNT_W'(BEAT_BYTES);
                    d.rem        = q.rem - CNT_W'(BEAT_BYTES);
                    d.st         = last_beat ? ST_REL : ST_RD;
                end
            end
            ST_REL: begin
                if (mem_gnt) begin
                    if (q.rem == '0) begin
                        d.st = ST_DONE;
                    end else begin
                        d.desc = q.nxt;
                        d.widx = 2'd0;
                        d.st   = ST_FREQ;
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign in_ready  = (q.st == ST_IN);
    assign out_valid = (q.st == ST_OUT);
    assign out_data  = q.hold;

endmodule

// File: rtl/sgdma_walker_chk.sv
module sgdma_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !in_ready && !out_valid && !done));

    // R5
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

endmodule

bind sg_dma_walker sgdma_walker_chk #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) u_walker_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_gnt  (mem_gnt),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_sg_dma_walker.sv
module tb_sg_dma_walker;

    localparam logic [31:0] SRC_BASE = 32'hC0DE_0000;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  tag;
    } op_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_to_mem = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] total_bytes = '0;
    logic        busy, done;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    int          done_cnt = 0;
    int          src_idx = 0;
    int          out_cnt = 0;
    bit          fast = 1'b0;
    bit          pend_rd = 1'b0;
    logic [31:0] pend_data = '0;
    logic [15:0] lfsr = 16'hACE1;
    op_t         cur_op;

    logic [31:0] mem_model [logic [31:0]];
    op_t         exp_ops [$];
    logic [31:0] exp_out [$];

    sg_dma_walker dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_to_mem (dir_to_mem),
        .base_addr  (base_addr),
        .total_bytes(total_bytes),
        .busy       (busy),
        .done       (done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return 32'h0;
    endfunction

    task automatic push_op(input logic we, input logic [31:0] a,
                           input logic [31:0] dat, input logic [7:0] tag);
        op_t o;
        o.we = we; o.addr = a; o.data = dat; o.tag = tag;
        exp_ops.push_back(o);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] st,
                            input logic [31:0] sz, input logic [31:0] bf,
                            input logic [31:0] nx);
        mem_model[a]      = st;
        mem_model[a + 4]  = sz;
        mem_model[a + 8]  = bf;
        mem_model[a + 12] = nx;
    endtask

    // Behavioural walk of the chain: builds the expected access list and stream
    task automatic plan(input logic [31:0] base, input int total, input bit to_mem);
        logic [31:0] dsc, stw, szw, bfw, nxw;
        int rem, eff, ch, k;
        dsc = base; rem = total; k = 0;
        while (rem > 0) begin
            stw = rd(dsc); szw = rd(dsc + 4); bfw = rd(dsc + 8); nxw = rd(dsc + 12);
            eff = (szw == 0) ? 65536 : int'(szw);
            ch  = (eff < rem) ? eff : rem;
            for (int i = 0; i < 4; i++) push_op(1'b0, dsc + 32'(4 * i), 32'h0, 8'd2);
            for (int w = 0; w < ch / 4; w++) begin
                if (to_mem) begin
                    push_op(1'b1, bfw + 32'(4 * w), SRC_BASE + 32'(k), 8'd5);
                    k++;
                end else begin
                    push_op(1'b0, bfw + 32'(4 * w), 32'h0, 8'd6);
                    exp_out.push_back(rd(bfw + 32'(4 * w)));
                end
            end
            push_op(1'b1, dsc, stw & 32'h7FFF_FFFF, 8'd7);
            rem -= ch;
            dsc = nxw;
        end
    endtask

    // Environment: drives inputs at the falling edge, observes handshakes just after
    always @(negedge clk) begin
        mem_rvalid = pend_rd;
        mem_rdata  = pend_data;
        pend_rd    = 1'b0;
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt    = fast | lfsr[0] | lfsr[1];
        in_valid   = fast | lfsr[2] | lfsr[3];
        out_ready  = fast | lfsr[4] | lfsr[5];
        in_data    = SRC_BASE + 32'(src_idx);
        #1;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (exp_ops.size() == 0) begin
                    chk(1'b0, "R8", "access after walk end, addr", mem_addr, 32'h0);
                end else begin
                    cur_op = exp_ops.pop_front();
                    chk(mem_we == cur_op.we && mem_addr == cur_op.addr &&
                        (!cur_op.we || mem_wdata == cur_op.data),
                        $sformatf("R%0d", cur_op.tag),
                        $sformatf("access we=%0d/%0d addr", mem_we, cur_op.we),
                        mem_we ? mem_wdata ^ mem_addr : mem_addr,
                        cur_op.we ? cur_op.data ^ cur_op.addr : cur_op.addr);
                end
                if (mem_we) begin
                    mem_model[mem_addr] = mem_wdata;
                end else begin
                    pend_rd   = 1'b1;
                    pend_data = rd(mem_addr);
                end
            end
            if (in_valid && in_ready) src_idx++;
            if (out_valid && out_ready) begin
                out_cnt++;
                if (exp_out.size() == 0) begin
                    chk(1'b0, "R6", "unexpected stream word", out_data, 32'h0);
                end else begin
                    chk(out_data == exp_out[0], "R6", "stream word", out_data, exp_out[0]);
                    void'(exp_out.pop_front());
                end
            end
            if (done) done_cnt++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_job(input logic [31:0] base, input int total, input bit to_mem,
                           input bit fast_i, input bit poke);
        plan(base, total, to_mem);
        fast = fast_i; src_idx = 0; done_cnt = 0; out_cnt = 0;
        @(negedge clk);
        base_addr = base; total_bytes = 32'(total); dir_to_mem = to_mem; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: a second start mid-walk with other base, count and direction
            repeat (15) @(negedge clk);
            base_addr = 32'h100; total_bytes = 32'd8; dir_to_mem = ~to_mem; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(exp_ops.size() == 0, poke ? "R11" : "R8", "expected accesses left",
            32'(exp_ops.size()), 32'h0);
        chk(exp_out.size() == 0, "R6", "expected stream words left", 32'(exp_out.size()), 32'h0);
        chk(done_cnt == 1, "R9", "done pulse count", 32'(done_cnt), 32'd1);
        chk(busy == 1'b0, "R9", "busy after done", 32'(busy), 32'h0);
        fast = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({busy, done, mem_req, in_ready, out_valid} == 5'b0, "R1", "outputs in reset",
            32'({busy, done, mem_req, in_ready, out_valid}), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, mem_req, in_ready, out_valid} == 5'b0, "R1", "outputs idle after reset",
            32'({busy, done, mem_req, in_ready, out_valid}), 32'h0);

        // Card to memory, chain 0x100 -> 0x300 -> 0x200, sizes 16, 8, 64, total 40 (R2 R3 R5 R7 R8)
        put_desc(32'h100, 32'h8000_0005, 32'd16, 32'h1000, 32'h300);
        put_desc(32'h300, 32'h8000_0A0A, 32'd8,  32'h2000, 32'h200);
        put_desc(32'h200, 32'hC000_0001, 32'd64, 32'h3000, 32'h400);
        put_desc(32'h400, 32'h8000_0000, 32'd16, 32'h4000, 32'h0);
        mem_model[32'h3010] = 32'hDEAD_BEEF;
        run_job(32'h100, 40, 1'b1, 1'b0, 1'b0);
        chk(rd(32'h100) == 32'h0000_0005, "R7", "status 0x100", rd(32'h100), 32'h0000_0005);
        chk(rd(32'h200) == 32'h4000_0001, "R7", "status 0x200", rd(32'h200), 32'h4000_0001);
        chk(rd(32'h400) == 32'h8000_0000, "R8", "unvisited status 0x400", rd(32'h400), 32'h8000_0000);
        chk(rd(32'h1000) == SRC_BASE, "R5", "first buffer word", rd(32'h1000), SRC_BASE);
        chk(rd(32'h300C) == SRC_BASE + 9, "R3", "last clipped word", rd(32'h300C), SRC_BASE + 9);
        chk(rd(32'h3010) == 32'hDEAD_BEEF, "R3", "word past clip", rd(32'h3010), 32'hDEAD_BEEF);

        // Memory to card with backpressure (R6)
        put_desc(32'h500, 32'h8000_0002, 32'd12, 32'h5000, 32'h600);
        put_desc(32'h600, 32'h8000_0003, 32'd12, 32'h6000, 32'h0);
        for (int i = 0; i < 3; i++) begin
            mem_model[32'h5000 + 32'(4 * i)] = 32'h5A00_0000 + 32'(i);
            mem_model[32'h6000 + 32'(4 * i)] = 32'h6B00_0000 + 32'(i);
        end
        run_job(32'h500, 24, 1'b0, 1'b0, 1'b0);
        chk(out_cnt == 6, "R6", "stream word count", 32'(out_cnt), 32'd6);
        chk(rd(32'h600) == 32'h0000_0003, "R7", "status 0x600", rd(32'h600), 32'h0000_0003);

        // Zero total: done with no access (R9)
        run_job(32'h100, 0, 1'b1, 1'b0, 1'b0);

        // Start while busy is ignored (R11), same chain re-armed
        put_desc(32'h500, 32'h8000_0002, 32'd12, 32'h5000, 32'h600);
        put_desc(32'h600, 32'h8000_0003, 32'd12, 32'h6000, 32'h0);
        mem_model[32'h100] = 32'h8000_0005;
        run_job(32'h500, 24, 1'b0, 1'b0, 1'b1);
        chk(rd(32'h100) == 32'h8000_0005, "R11", "status of poked base untouched",
            rd(32'h100), 32'h8000_0005);

        // Zero length word means 64 KiB, followed by a clipped chunk (R4)
        put_desc(32'h700, 32'h8000_0000, 32'd0,  32'h0001_0000, 32'h710);
        put_desc(32'h710, 32'h8000_0000, 32'd32, 32'h0004_0000, 32'h0);
        mem_model[32'h0004_0008] = 32'hFEED_F00D;
        run_job(32'h700, 65536 + 8, 1'b1, 1'b1, 1'b0);
        chk(rd(32'h0001_FFFC) == SRC_BASE + 16383, "R4", "last word of 64 KiB buffer",
            rd(32'h0001_FFFC), SRC_BASE + 16383);
        chk(rd(32'h0004_0000) == SRC_BASE + 16384, "R4", "first word of next buffer",
            rd(32'h0004_0000), SRC_BASE + 16384);
        chk(rd(32'h0004_0008) == 32'hFEED_F00D, "R3", "word past clip after 64 KiB",
            rd(32'h0004_0008), 32'hFEED_F00D);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule